// File: doc/BRIEF.md
# Integer Register Rename Map Unit

This block gives every integer destination write in an out-of-order pipeline a fresh physical register, so that later consumers can track dependencies purely by physical register number. It keeps a map table from logical registers (r1 to r31, plus the Hi and Lo multiply/divide result registers at logical 32 and 33) to 6-bit physical tags. Alongside it sit a circular free list of unassigned physical registers and a busy table with one bit per physical register. Logical r0 is hard-wired: it always reads as physical 0, never busy, and never consumes a free-list entry.

In each cycle a group of up to `RN_W` rename requests is presented, each with two source logical numbers and one destination. The block answers combinationally in the same cycle. For every slot it returns the two source tags with their busy flags, the newly assigned destination tag and the mapping that the destination replaces. Slots inside a group are resolved in slot order, so a later slot observes the renames of earlier ones. The group is accepted as a whole only when the free list can cover all of its destinations. Three other inputs update the state: writeback notices clear busy bits, graduation frees return old tags to the free list tail, and a restore port rewrites one map entry. A recovery engine uses the restore port to undo speculative renames.

Top module: `rnm_map_unit`

## Requirements
- R1: After reset, logical k (1 to 33) maps to physical k, logical 0 reads as physical 0, no register reads busy, and the free list holds physical 34 to 63 in ascending order with 34 at the head.
- R2: A logical number of 0 or of 34 and above is never renamed: as a source it returns tag 0 and not busy; as a destination it returns destination tag 0 and old tag 0 and consumes no free-list entry.
- R3: Each accepted slot with a renamable destination takes the next free-list entry in slot order, becomes the new mapping of that logical register, and reads busy from the following cycle.
- R4: Within one group, a source of slot i that names the destination of an earlier slot j < i returns slot j's new tag with busy set. A slot's own sources see the mapping from before its own destination.
- R5: The old destination tag equals the mapping in force just before that slot's rename, including a rename by an earlier slot of the same group.
- R6: `renReady` is high exactly when the free-list count is at least the number of valid slots with a renamable destination. When it is low, or no slot is valid, the map, busy table and free-list head do not change.
- R7: A writeback notice clears the busy bit of its tag; the cleared state is seen from the next cycle.
- R8: A free of a nonzero tag appends it at the free-list tail, in port order, after the entries already queued; a free of tag 0 is ignored.
- R9: A restore to a renamable logical register sets its mapping from the next cycle and overrides a rename of the same register accepted in the same cycle; a restore of an unrenamable logical number is ignored.
- R10: The free list is a 32-entry circular queue whose head and tail wrap, and its count never exceeds 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | RN_W | Per-slot rename request valid |
| reqSrcA | input | RN_W x 6 | First source logical number per slot |
| reqSrcB | input | RN_W x 6 | Second source logical number per slot |
| reqDst | input | RN_W x 6 | Destination logical number per slot |
| renReady | output | 1 | Free list can cover the current group |
| srcATag | output | RN_W x 6 | Physical tag of first source |
| srcABusy | output | RN_W | First source value still pending |
| srcBTag | output | RN_W x 6 | Physical tag of second source |
| srcBBusy | output | RN_W | Second source value still pending |
| dstTag | output | RN_W x 6 | Newly assigned destination tag (0 when none) |
| oldDstTag | output | RN_W x 6 | Mapping replaced by the destination |
| wbValid | input | WB_W | Writeback notice valid |
| wbTag | input | WB_W x 6 | Physical tag written by an execution unit |
| freeValid | input | FR_W | Graduation free valid |
| freeTag | input | FR_W x 6 | Physical tag returned to the free list |
| restoreValid | input | 1 | Map entry rewrite valid |
| restoreLog | input | 6 | Logical register to rewrite |
| restoreTag | input | 6 | Physical tag to install |

## Verification
The hardest state to reach from the ports is a free list that has wrapped several times while holding tags in a non-trivial order. This matters most when the list is nearly empty, where a group is refused for one slot too many. The bench handles the first case with a long pseudo-random phase. Frees are held back until their tag has been written back, so tags return in a scrambled order and the head and tail wrap many times. For the boundary, it first drains the list to exactly one entry with one single-slot rename followed by paired renames, then offers a two-destination group and a one-destination group. Restore is reached by renaming a register and then undoing it, both in a later cycle and in the same cycle as a competing rename.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  localparam int LOG_W    = 6;
  localparam int NUM_LOG  = 34;
  localparam int PHYS_W   = 6;
  localparam int NUM_PHYS = 2 ** PHYS_W;
  localparam int FL_DEPTH = 32;
  localparam int FL_PTR_W = $clog2(FL_DEPTH);
  localparam int FL_CNT_W = FL_PTR_W + 1;
  localparam int FL_INIT  = NUM_PHYS - NUM_LOG;
  localparam int RN_W     = 2;
  localparam int FR_W     = 2;
  localparam int WB_W     = 2;

  typedef logic [LOG_W-1:0]  logIdx_t;
  typedef logic [PHYS_W-1:0] physTag_t;

  typedef struct packed {
    logic                          accept;
    logic [RN_W-1:0]               allocEn;
    logic [RN_W-1:0][FL_PTR_W-1:0] allocOfs;
    logic [FL_CNT_W-1:0]           popCount;
    logic [FR_W-1:0]               pushEn;
    logic [FR_W-1:0][FL_PTR_W-1:0] pushOfs;
    logic [FL_CNT_W-1:0]           pushCount;
  } rnStrobe_t;

  function automatic logic isReg(logIdx_t l);
    return (l != '0) && (l < LOG_W'(NUM_LOG));
  endfunction
endpackage

// File: rtl/rnm_ctrl.sv
module rnm_ctrl
  import rnm_pkg::*;
(
  input  logic [RN_W-1:0]             reqValid,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqDst,
  input  logic [FR_W-1:0]             freeValid,
  input  logic [FR_W-1:0][PHYS_W-1:0] freeTag,
  input  logic [FL_CNT_W-1:0]         flCount,
  output rnStrobe_t                   strb,
  output logic                        renReady
);
  logic [FL_CNT_W-1:0] nAlloc;
  logic [FL_CNT_W-1:0] nPush;

  always_comb begin
    strb   = '0;
    nAlloc = '0;
    nPush  = '0;
    // slot order fixes which free-list entry each destination takes
    for (int i = 0; i < RN_W; i++) begin
      strb.allocEn[i]  = reqValid[i] && isReg(reqDst[i]);
      strb.allocOfs[i] = nAlloc[FL_PTR_W-1:0];
      nAlloc           = nAlloc + FL_CNT_W'(strb.allocEn[i]);
    end
    for (int k = 0; k < FR_W; k++) begin
      strb.pushEn[k]  = freeValid[k] && (freeTag[k] != '0);
      strb.pushOfs[k] = nPush[FL_PTR_W-1:0];
      nPush           = nPush + FL_CNT_W'(strb.pushEn[k]);
    end
    renReady       = (flCount >= nAlloc);
    strb.accept    = renReady && (|reqValid);
    strb.popCount  = strb.accept ? nAlloc : '0;
    strb.pushCount = nPush;
  end
endmodule

// File: rtl/rnm_datapath.sv
module rnm_datapath
  import rnm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  rnStrobe_t                   strb,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqSrcA,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqSrcB,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqDst,
  output logic [RN_W-1:0][PHYS_W-1:0] srcATag,
  output logic [RN_W-1:0]             srcABusy,
  output logic [RN_W-1:0][PHYS_W-1:0] srcBTag,
  output logic [RN_W-1:0]             srcBBusy,
  output logic [RN_W-1:0][PHYS_W-1:0] dstTag,
  output logic [RN_W-1:0][PHYS_W-1:0] oldDstTag,
  input  logic [WB_W-1:0]             wbValid,
  input  logic [WB_W-1:0][PHYS_W-1:0] wbTag,
  input  logic [FR_W-1:0][PHYS_W-1:0] freeTag,
  input  logic                        restoreValid,
  input  logic [LOG_W-1:0]            restoreLog,
  input  logic [PHYS_W-1:0]           restoreTag,
  output logic [FL_CNT_W-1:0]         flCount
);
  physTag_t            mapTbl  [NUM_LOG];
  physTag_t            flMem   [FL_DEPTH];
  logic [NUM_PHYS-1:0] busyTbl;
  logic [FL_PTR_W-1:0] flHead;
  logic [FL_PTR_W-1:0] flTail;

  physTag_t            wMap    [NUM_LOG];
  physTag_t            nextMap [NUM_LOG];
  physTag_t            newTag  [RN_W];
  logic [NUM_PHYS-1:0] wBusy;
  logic [NUM_PHYS-1:0] nextBusy;

  // Group resolution: each slot reads the working copy left by earlier slots
  always_comb begin
    wMap  = mapTbl;
    wBusy = busyTbl;
    for (int i = 0; i < RN_W; i++) begin
      newTag[i]    = flMem[flHead + strb.allocOfs[i]];
      srcATag[i]   = isReg(reqSrcA[i]) ? wMap[reqSrcA[i]] : '0;
      srcABusy[i]  = isReg(reqSrcA[i]) && wBusy[srcATag[i]];
      srcBTag[i]   = isReg(reqSrcB[i]) ? wMap[reqSrcB[i]] : '0;
      srcBBusy[i]  = isReg(reqSrcB[i]) && wBusy[srcBTag[i]];
      oldDstTag[i] = isReg(reqDst[i]) ? wMap[reqDst[i]] : '0;
      dstTag[i]    = strb.allocEn[i] ? newTag[i] : '0;
      if (strb.allocEn[i]) begin
        wMap[reqDst[i]]   = newTag[i];
        wBusy[newTag[i]]  = 1'b1;
      end
    end
  end

  // Next state: rename first, restore overrides, writeback clears last
  always_comb begin
    if (strb.accept) begin
      nextMap  = wMap;
      nextBusy = wBusy;
    end else begin
      nextMap  = mapTbl;
      nextBusy = busyTbl;
    end
    if (restoreValid && isReg(restoreLog)) nextMap[restoreLog] = restoreTag;
    for (int k = 0; k < WB_W; k++) begin
      if (wbValid[k]) nextBusy[wbTag[k]] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_LOG; i++) mapTbl[i] <= PHYS_W'(i);
      for (int k = 0; k < FL_DEPTH; k++)
        flMem[k] <= (k < FL_INIT) ? PHYS_W'(NUM_LOG + k) : '0;
      busyTbl <= '0;
      flHead  <= '0;
      flTail  <= FL_PTR_W'(FL_INIT);
      flCount <= FL_CNT_W'(FL_INIT);
    end else begin
      mapTbl  <= nextMap;
      busyTbl <= nextBusy;
      for (int k = 0; k < FR_W; k++) begin
        if (strb.pushEn[k]) flMem[flTail + strb.pushOfs[k]] <= freeTag[k];
      end
      flHead  <= flHead + strb.popCount[FL_PTR_W-1:0];
      flTail  <= flTail + strb.pushCount[FL_PTR_W-1:0];
      flCount <= flCount - strb.popCount + strb.pushCount;
    end
  end

  // Queue occupancy stays within the physical storage
  p_fl_bound_r10: assert property (@(posedge clk) disable iff (!rstN)
    flCount <= FL_CNT_W'(FL_DEPTH));

  // A refused or empty group leaves the queue head and count alone
  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!strb.accept && strb.pushCount == '0) |=> ($stable(flCount) && $stable(flHead)));

  // A restore lands in the map table on the next edge
  p_restore_r9: assert property (@(posedge clk) disable iff (!rstN)
    (restoreValid && isReg(restoreLog)) |=> (mapTbl[$past(restoreLog)] == $past(restoreTag)));

  for (genvar i = 0; i < RN_W; i++) begin : g_slotChk
    p_alloc_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
      (strb.accept && strb.allocEn[i] && wbValid == '0) |=> busyTbl[$past(dstTag[i])]);
    p_zero_reg_r2: assert property (@(posedge clk) disable iff (!rstN)
      !isReg(reqDst[i]) |-> (dstTag[i] == '0 && oldDstTag[i] == '0));
  end

  for (genvar k = 0; k < WB_W; k++) begin : g_wbChk
    p_wb_clear_r7: assert property (@(posedge clk) disable iff (!rstN)
      (wbValid[k] && !strb.accept) |=> !busyTbl[$past(wbTag[k])]);
  end
endmodule

// File: rtl/rnm_map_unit.sv
module rnm_map_unit
  import rnm_pkg::*;
(
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [RN_W-1:0]             reqValid,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqSrcA,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqSrcB,
  input  logic [RN_W-1:0][LOG_W-1:0]  reqDst,
  output logic                        renReady,
  output logic [RN_W-1:0][PHYS_W-1:0] srcATag,
  output logic [RN_W-1:0]             srcABusy,
  output logic [RN_W-1:0][PHYS_W-1:0] srcBTag,
  output logic [RN_W-1:0]             srcBBusy,
  output logic [RN_W-1:0][PHYS_W-1:0] dstTag,
  output logic [RN_W-1:0][PHYS_W-1:0] oldDstTag,
  input  logic [WB_W-1:0]             wbValid,
  input  logic [WB_W-1:0][PHYS_W-1:0] wbTag,
  input  logic [FR_W-1:0]             freeValid,
  input  logic [FR_W-1:0][PHYS_W-1:0] freeTag,
  input  logic                        restoreValid,
  input  logic [LOG_W-1:0]            restoreLog,
  input  logic [PHYS_W-1:0]           restoreTag
);
  rnStrobe_t           strb;
  logic [FL_CNT_W-1:0] flCount;

  rnm_ctrl u_ctrl (
    .reqValid (reqValid),
    .reqDst   (reqDst),
    .freeValid(freeValid),
    .freeTag  (freeTag),
    .flCount  (flCount),
    .strb     (strb),
    .renReady (renReady)
  );

  rnm_datapath u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .reqSrcA     (reqSrcA),
    .reqSrcB     (reqSrcB),
    .reqDst      (reqDst),
    .srcATag     (srcATag),
    .srcABusy    (srcABusy),
    .srcBTag     (srcBTag),
    .srcBBusy    (srcBBusy),
    .dstTag      (dstTag),
    .oldDstTag   (oldDstTag),
    .wbValid     (wbValid),
    .wbTag       (wbTag),
    .freeTag     (freeTag),
    .restoreValid(restoreValid),
    .restoreLog  (restoreLog),
    .restoreTag  (restoreTag),
    .flCount     (flCount)
  );
endmodule

// File: tb/rnm_map_unit_bench.sv
module rnm_map_unit_bench;
  import rnm_pkg::*;

  logic                        clk = 1'b0;
  logic                        rstN = 1'b0;
  logic [RN_W-1:0]             reqValid;
  logic [RN_W-1:0][LOG_W-1:0]  reqSrcA, reqSrcB, reqDst;
  logic                        renReady;
  logic [RN_W-1:0][PHYS_W-1:0] srcATag, srcBTag, dstTag, oldDstTag;
  logic [RN_W-1:0]             srcABusy, srcBBusy;
  logic [WB_W-1:0]             wbValid;
  logic [WB_W-1:0][PHYS_W-1:0] wbTag;
  logic [FR_W-1:0]             freeValid;
  logic [FR_W-1:0][PHYS_W-1:0] freeTag;
  logic                        restoreValid;
  logic [LOG_W-1:0]            restoreLog;
  logic [PHYS_W-1:0]           restoreTag;

  always #4ns clk = ~clk;

  rnm_map_unit u_rnm_map_unit (.*);

  // Requirement-level model of the unit
  int mMap [NUM_LOG];
  bit mBusy [NUM_PHYS];
  int mFl [FL_DEPTH];
  int mHead, mTail, mCnt;
  int gq [256];
  int gqHead, gqCnt;
  int lastNew [RN_W];
  int lastOld [RN_W];
  int nCmp = 0, nBad = 0;
  bit done = 1'b0;

  function automatic bit isRegB(int l);
    return (l != 0) && (l < NUM_LOG);
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic clearIn();
    reqValid = '0; reqSrcA = '0; reqSrcB = '0; reqDst = '0;
    wbValid = '0; wbTag = '0; freeValid = '0; freeTag = '0;
    restoreValid = 1'b0; restoreLog = '0; restoreTag = '0;
  endtask

  // One cycle: check outputs mid-cycle, then advance the model past the edge
  task automatic step(string req);
    int tMap [NUM_LOG];
    bit tBusy [NUM_PHYS];
    int need = 0, ofs = 0, ea, eb, eo, nt;
    bit expReady, acc;
    tMap = mMap; tBusy = mBusy;
    for (int i = 0; i < RN_W; i++)
      if (reqValid[i] && isRegB(int'(reqDst[i]))) need++;
    expReady = (mCnt >= need);
    acc = expReady && (reqValid != '0);
    @(negedge clk); #1;
    chk(req, "ready", int'(renReady), int'(expReady));
    for (int i = 0; i < RN_W; i++) begin
      ea = isRegB(int'(reqSrcA[i])) ? tMap[reqSrcA[i]] : 0;
      eb = isRegB(int'(reqSrcB[i])) ? tMap[reqSrcB[i]] : 0;
      eo = isRegB(int'(reqDst[i])) ? tMap[reqDst[i]] : 0;
      if (expReady) begin
        chk(req, "srcATag", int'(srcATag[i]), ea);
        chk(req, "srcABusy", int'(srcABusy[i]), isRegB(int'(reqSrcA[i])) ? int'(tBusy[ea]) : 0);
        chk(req, "srcBTag", int'(srcBTag[i]), eb);
        chk(req, "srcBBusy", int'(srcBBusy[i]), isRegB(int'(reqSrcB[i])) ? int'(tBusy[eb]) : 0);
      end
      lastNew[i] = 0; lastOld[i] = eo;
      if (reqValid[i] && isRegB(int'(reqDst[i]))) begin
        nt = mFl[(mHead + ofs) % FL_DEPTH];
        ofs++;
        if (expReady) begin
          chk(req, "dstTag", int'(dstTag[i]), nt);
          chk(req, "oldDstTag", int'(oldDstTag[i]), eo);
        end
        tMap[reqDst[i]] = nt; tBusy[nt] = 1'b1; lastNew[i] = nt;
      end else if (reqValid[i] && expReady) begin
        chk(req, "dstTag", int'(dstTag[i]), 0);
        chk(req, "oldDstTag", int'(oldDstTag[i]), eo);
      end
    end
    @(posedge clk); #1;
    if (acc) begin
      mMap = tMap; mBusy = tBusy;
      mHead = (mHead + ofs) % FL_DEPTH; mCnt -= ofs;
      for (int i = 0; i < RN_W; i++)
        if (lastNew[i] != 0 && lastOld[i] != 0) begin
          gq[(gqHead + gqCnt) % 256] = lastOld[i]; gqCnt++;
        end
    end else begin
      for (int i = 0; i < RN_W; i++) lastNew[i] = 0;
    end
    if (restoreValid && isRegB(int'(restoreLog))) mMap[restoreLog] = int'(restoreTag);
    for (int k = 0; k < WB_W; k++) if (wbValid[k]) mBusy[wbTag[k]] = 1'b0;
    for (int k = 0; k < FR_W; k++)
      if (freeValid[k] && freeTag[k] != '0) begin
        mFl[mTail] = int'(freeTag[k]); mTail = (mTail + 1) % FL_DEPTH; mCnt++;
      end
  endtask

  // Pick up to two busy tags for writeback, starting at a given offset
  task automatic pickWb(int start);
    int n = 0;
    for (int j = 0; j < NUM_PHYS; j++) begin
      int t = (start + j) % NUM_PHYS;
      if (n < WB_W && mBusy[t]) begin
        wbValid[n] = 1'b1; wbTag[n] = PHYS_W'(t); n++;
      end
    end
  endtask

  // Free graduated tags whose values have been written back
  task automatic pickFree(bit allow);
    int n = 0;
    while (allow && n < FR_W && gqCnt > 0 && !mBusy[gq[gqHead]]) begin
      freeValid[n] = 1'b1; freeTag[n] = PHYS_W'(gq[gqHead]);
      gqHead = (gqHead + 1) % 256; gqCnt--; n++;
    end
  endtask

  task automatic settle(string req);
    bit anyBusy = 1'b1;
    while (anyBusy || gqCnt > 0) begin
      clearIn();
      pickWb(0);
      pickFree(1'b1);
      step(req);
      anyBusy = 1'b0;
      for (int t = 0; t < NUM_PHYS; t++) if (mBusy[t]) anyBusy = 1'b1;
    end
  endtask

  initial begin
    #(8ns * 150000);
    if (!done) begin
      nCmp++; nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    int savedOld, savedNew;
    clearIn();
    for (int i = 0; i < NUM_LOG; i++) mMap[i] = i;
    for (int t = 0; t < NUM_PHYS; t++) mBusy[t] = 1'b0;
    for (int k = 0; k < FL_DEPTH; k++) mFl[k] = (k < FL_INIT) ? NUM_LOG + k : 0;
    mHead = 0; mTail = FL_INIT; mCnt = FL_INIT; gqHead = 0; gqCnt = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: identity map, nothing busy, after reset
    for (int l = 0; l < NUM_LOG; l++) begin
      clearIn();
      reqSrcA[0] = LOG_W'(l); reqSrcB[0] = LOG_W'(l);
      reqSrcA[1] = LOG_W'((l + 1) % NUM_LOG); reqSrcB[1] = LOG_W'((l + 7) % NUM_LOG);
      step("R1");
    end

    // R2: r0 and out-of-range logical numbers are never renamed
    clearIn();
    reqValid = 2'b11; reqDst[0] = '0; reqDst[1] = LOG_W'(40);
    reqSrcA[0] = '0; reqSrcB[1] = LOG_W'(50);
    step("R2");
    // R1: head of free list is still physical 34
    clearIn(); reqValid = 2'b01; reqDst[0] = LOG_W'(9);
    step("R1");
    chk("R1", "first alloc", lastNew[0], 34);

    // R4/R5: same register renamed twice in one group, read by the later slot
    clearIn();
    reqValid = 2'b11; reqDst[0] = LOG_W'(3); reqDst[1] = LOG_W'(3);
    reqSrcA[0] = LOG_W'(3); reqSrcA[1] = LOG_W'(3); reqSrcB[1] = LOG_W'(9);
    step("R4");
    chk("R5", "slot1 old", lastOld[1], lastNew[0]);
    // R3: new mapping visible and busy next cycle
    clearIn(); reqSrcA[0] = LOG_W'(3);
    step("R3");

    // R7: writebacks clear busy; R8: frees append
    settle("R8");
    clearIn(); reqSrcA[0] = LOG_W'(3); reqSrcB[1] = LOG_W'(9);
    step("R7");
    // R8: free of tag 0 is ignored
    clearIn(); freeValid = 2'b01; freeTag[0] = '0;
    step("R8");

    // R6: drain to exactly one entry, then probe the boundary
    clearIn(); reqValid = 2'b01; reqDst[0] = LOG_W'(1);
    step("R6");
    while (mCnt >= 2) begin
      clearIn(); reqValid = 2'b11; reqDst[0] = LOG_W'(2); reqDst[1] = LOG_W'(4);
      step("R6");
    end
    chk("R6", "model count", mCnt, 1);
    clearIn(); reqValid = 2'b11; reqDst[0] = LOG_W'(5); reqDst[1] = LOG_W'(6);
    reqSrcA[1] = LOG_W'(5);
    step("R6");
    clearIn(); reqSrcA[0] = LOG_W'(5); reqSrcA[1] = LOG_W'(6);
    step("R6");
    clearIn(); reqValid = 2'b11; reqDst[0] = '0; reqDst[1] = LOG_W'(6);
    step("R6");
    clearIn(); reqValid = 2'b11; reqDst[0] = LOG_W'(7); reqDst[1] = '0;
    step("R6");
    clearIn(); reqValid = 2'b11; reqDst[0] = '0; reqDst[1] = LOG_W'(35);
    step("R6");
    settle("R8");

    // R10 and general behaviour: long pseudo-random run with wraparound
    for (int c = 0; c < 4000; c++) begin
      clearIn();
      for (int i = 0; i < RN_W; i++) begin
        reqValid[i] = ($urandom % 4) != 0;
        reqSrcA[i]  = LOG_W'($urandom % 36);
        reqSrcB[i]  = LOG_W'($urandom % 36);
        reqDst[i]   = LOG_W'($urandom % 36);
      end
      if (($urandom % 3) != 0) pickWb(int'($urandom % NUM_PHYS));
      pickFree(($urandom % 4) != 0);
      if (c % 2 == 0) step("R10"); else step("R5");
    end
    settle("R8");

    // R9: rename then undo one cycle later
    clearIn(); reqValid = 2'b01; reqDst[0] = LOG_W'(5);
    step("R9");
    savedNew = lastNew[0]; savedOld = lastOld[0];
    gqCnt--;
    clearIn();
    restoreValid = 1'b1; restoreLog = LOG_W'(5); restoreTag = PHYS_W'(savedOld);
    freeValid[0] = 1'b1; freeTag[0] = PHYS_W'(savedNew);
    wbValid[0] = 1'b1; wbTag[0] = PHYS_W'(savedNew);
    step("R9");
    clearIn(); reqSrcA[0] = LOG_W'(5);
    step("R9");
    chk("R9", "undo map", mMap[5], savedOld);

    // R9: restore overrides a same-cycle rename of the same register
    savedOld = mMap[7];
    clearIn(); reqValid = 2'b01; reqDst[0] = LOG_W'(7);
    restoreValid = 1'b1; restoreLog = LOG_W'(7); restoreTag = PHYS_W'(savedOld);
    step("R9");
    savedNew = lastNew[0];
    gqCnt--;
    clearIn(); reqSrcA[0] = LOG_W'(7); reqSrcB[0] = LOG_W'(7);
    freeValid[0] = 1'b1; freeTag[0] = PHYS_W'(savedNew);
    wbValid[0] = 1'b1; wbTag[0] = PHYS_W'(savedNew);
    step("R9");
    // R9: restore of r0 is ignored
    clearIn(); restoreValid = 1'b1; restoreLog = '0; restoreTag = PHYS_W'(20);
    step("R9");
    clearIn(); reqSrcA[0] = '0; reqSrcB[1] = LOG_W'(7);
    step("R9");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule